// File: doc/BRIEF.md
# Auto-Reload Up-Counter Timer with Buffered Reload

The block is a free-running up-counter. It raises an update event and returns to zero when its value equals an active reload value. Software reaches it through a small register port: a control word, the reload value, the live count, and a sticky status flag. The flag drives the interrupt line. An external clock-enable tick paces the counting, together with a run bit.

The reload value can be buffered. With buffering on, a write lands in a holding register and reaches the compare register only at the next update event. A shorter period therefore always starts cleanly at zero. With buffering off, a write reaches the compare register at once. A new value below the current count then lets the counter run on to full scale and wrap before the next match.

Software can also force an update. Update events can be suppressed, and the flag can be limited to real counter matches.

Top module: `rtimer_top`

## Requirements
- R1: On a cycle where the counter advances and its value equals the active reload value, the next count is zero. The period is therefore reload+1 ticks.
- R2: On any other advancing cycle the count rises by one. From all ones it wraps to zero with no update event and no flag.
- R3: With buffering off (control bit 3 = 0), a write to the reload register (address 1) replaces the compare value at once. A value below the current count gives the next match only after a full wraparound.
- R4: With buffering on (control bit 3 = 1), a reload write is read back at address 1 at once, but the compare value stays unchanged until an update event.
- R5: At an update event with buffering on, the held reload value becomes the compare value, and it governs the period that follows.
- R6: Every update event sets the status flag (address 3, bit 0). The output `irq` equals that flag.
- R7: While update-disable (control bit 1) is 1, a match still returns the count to zero, but no reload transfer happens and the flag is not set.
- R8: Writing control with bit 4 = 1 forces an update: the count goes to zero and the held reload value is transferred. Bit 4 always reads back 0.
- R9: With match-only flagging (control bit 2 = 1), a forced update does not set the flag, while a counter match still does.
- R10: The flag stays set until software writes 0 to status bit 0. Writing 1 there has no effect.
- R11: The count changes only when run (control bit 0) and `tick` are both 1, apart from register writes and forced updates.
- R12: After reset, control, count and flag read 0 and the reload value reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 reload, 2 count, 3 status |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the selected register (combinational) |
| tick | input | 1 | Count enable pulse |
| irq | output | 1 | Update interrupt, equal to the status flag |

## Verification
The assertions assume a write to the count register never coincides with an advancing cycle. They also assume a forced update is written with the same mode bits that are already in force, since the update logic uses the settings in place before the write. The directed stimulus keeps `tick` low during every register write. Each forced update repeats the current control word with only bit 4 added. Wraparound is reached by loading the count near full scale instead of counting there.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
   localparam int unsigned CTRL_W = 5;

   typedef struct packed {
      logic force_upd;   // bit 4, pulse only
      logic buffer_en;   // bit 3
      logic match_only;  // bit 2
      logic upd_off;     // bit 1
      logic run;         // bit 0
   } ctrl_t;

   localparam logic [1:0] ADDR_CTRL   = 2'd0;
   localparam logic [1:0] ADDR_RELOAD = 2'd1;
   localparam logic [1:0] ADDR_COUNT  = 2'd2;
   localparam logic [1:0] ADDR_STATUS = 2'd3;
endpackage

// File: rtl/rtimer_ctrl.sv
module rtimer_ctrl
   import rtimer_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_status,
   input  logic [CTRL_W-1:0] wbits,
   input  logic              flag_set,
   output ctrl_t             ctrl,
   output logic              flag_q
);
   ctrl_t mode_q;
   logic  flag_clr;

   assign flag_clr = wr_status && !wbits[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (wr_ctrl) begin
         mode_q           <= ctrl_t'(wbits);
         mode_q.force_upd <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (flag_set) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   always_comb begin
      ctrl           = mode_q;
      ctrl.force_upd = wr_ctrl && wbits[4];
   end

   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !flag_clr |=> flag_q);
   // R6
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(flag_set));
   // R8
   force_noretain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q.force_upd);
endmodule

// File: rtl/rtimer_reload.sv
module rtimer_reload #(
   parameter int unsigned W            = 32,
   parameter bit          PRELOAD_IMPL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_reload,
   input  logic [W-1:0] wdata,
   input  logic         buffer_en,
   input  logic         load_ev,
   output logic [W-1:0] held_q,
   output logic [W-1:0] active_q
);
   generate
      if (PRELOAD_IMPL) begin : g_buffered
         logic [W-1:0] hold_r, act_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         hold_r <= '1;
            else if (wr_reload) hold_r <= wdata;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        act_r <= '1;
            else if (wr_reload && !buffer_en)  act_r <= wdata;
            else if (load_ev)                  act_r <= hold_r;
         end

         assign held_q   = hold_r;
         assign active_q = act_r;

         // R4
         buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            buffer_en && !load_ev |=> $stable(act_r));
         // R5
         transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_ev && !(wr_reload && !buffer_en) |=> act_r == $past(hold_r));
      end else begin : g_direct
         logic [W-1:0] act_r;
         logic         unused_ok;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         act_r <= '1;
            else if (wr_reload) act_r <= wdata;
         end

         assign held_q    = act_r;
         assign active_q  = act_r;
         assign unused_ok = buffer_en ^ load_ev;
      end
   endgenerate
endmodule

// File: rtl/rtimer_counter.sv
module rtimer_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  logic         clear,
   input  logic         cnt_wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] reload,
   output logic [W-1:0] cnt_q,
   output logic         match
);
   assign match = advance && !cnt_wr && (cnt_q == reload);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (cnt_wr)  cnt_q <= wdata;
      else if (clear)   cnt_q <= '0;
      else if (match)   cnt_q <= '0;
      else if (advance) cnt_q <= cnt_q + W'(1);
   end

   // R1
   match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !cnt_wr && cnt_q == reload |=> cnt_q == '0);
   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !cnt_wr && !clear && cnt_q != reload
         |=> cnt_q == $past(cnt_q) + W'(1));
   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !advance && !cnt_wr && !clear |=> $stable(cnt_q));
endmodule

// File: rtl/rtimer_top.sv
module rtimer_top
   import rtimer_pkg::*;
#(
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned DATA_W       = 32,
   parameter bit          PRELOAD_IMPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tick,
   output logic              irq
);
   localparam int unsigned PAD_W = DATA_W - CNT_W;

   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
         $error("rtimer_top: CNT_W must lie in 2..64");
      end
      if (DATA_W < CNT_W || DATA_W < CTRL_W) begin : g_bad_data
         $error("rtimer_top: DATA_W must cover CNT_W and the control word");
      end
   endgenerate

   logic wr_ctrl, wr_reload, wr_count, wr_status;
   assign wr_ctrl   = wr_en && addr == ADDR_CTRL;
   assign wr_reload = wr_en && addr == ADDR_RELOAD;
   assign wr_count  = wr_en && addr == ADDR_COUNT;
   assign wr_status = wr_en && addr == ADDR_STATUS;

   ctrl_t            ctrl;
   logic             flag_q, flag_set, match, upd_ev, advance;
   logic [CNT_W-1:0] held_q, active_q, cnt_q;

   assign advance  = ctrl.run && tick;
   assign upd_ev   = (match || ctrl.force_upd) && !ctrl.upd_off;
   assign flag_set = upd_ev && (match || !ctrl.match_only);

   rtimer_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wr_status(wr_status),
      .wbits    (wdata[CTRL_W-1:0]),
      .flag_set (flag_set),
      .ctrl     (ctrl),
      .flag_q   (flag_q)
   );

   rtimer_reload #(.W(CNT_W), .PRELOAD_IMPL(PRELOAD_IMPL)) u_reload (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_reload(wr_reload),
      .wdata    (wdata[CNT_W-1:0]),
      .buffer_en(ctrl.buffer_en),
      .load_ev  (upd_ev),
      .held_q   (held_q),
      .active_q (active_q)
   );

   rtimer_counter #(.W(CNT_W)) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .advance(advance),
      .clear  (ctrl.force_upd),
      .cnt_wr (wr_count),
      .wdata  (wdata[CNT_W-1:0]),
      .reload (active_q),
      .cnt_q  (cnt_q),
      .match  (match)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         logic [DATA_W-1:0] held_x, cnt_x;
         assign held_x = {{PAD_W{1'b0}}, held_q};
         assign cnt_x  = {{PAD_W{1'b0}}, cnt_q};
         always_comb begin
            unique case (addr)
               ADDR_CTRL:   rdata = DATA_W'({1'b0, ctrl.buffer_en, ctrl.match_only,
                                             ctrl.upd_off, ctrl.run});
               ADDR_RELOAD: rdata = held_x;
               ADDR_COUNT:  rdata = cnt_x;
               default:     rdata = DATA_W'(flag_q);
            endcase
         end
      end else begin : g_nopad
         always_comb begin
            unique case (addr)
               ADDR_CTRL:   rdata = DATA_W'({1'b0, ctrl.buffer_en, ctrl.match_only,
                                             ctrl.upd_off, ctrl.run});
               ADDR_RELOAD: rdata = held_q;
               ADDR_COUNT:  rdata = cnt_q;
               default:     rdata = DATA_W'(flag_q);
            endcase
         end
      end
   endgenerate

   assign irq = flag_q;

   // R7
   upd_off_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.upd_off |=> !$rose(flag_q));
   // R9
   match_only_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.match_only && ctrl.force_upd && !match |=> !$rose(flag_q));
   // R2
   wrap_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !wr_count && !ctrl.force_upd && cnt_q == '1 && active_q != '1
         |=> !$rose(flag_q));
endmodule

// File: tb/rtimer_top_tb_top.sv
module rtimer_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tick = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   rtimer_top dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick(tick), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic expect_cnt_flag(input string req, input logic [31:0] c, input logic f);
      logic [31:0] v;
      rd(2'd2, v); chk({req, " count"}, v, c);
      rd(2'd3, v); chk({req, " flag"}, v, {31'd0, f});
      chk({req, " irq"}, {31'd0, irq}, {31'd0, f});
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(2'd0, v); chk("R12 ctrl", v, 32'd0);
      rd(2'd1, v); chk("R12 reload", v, 32'hFFFF_FFFF);
      expect_cnt_flag("R12", 32'd0, 1'b0);
   endtask

   task automatic t_basic;
      logic [31:0] v;
      wr(2'd1, 32'd4);
      wr(2'd0, 32'd1);
      ticks(4); expect_cnt_flag("R1 before match", 32'd4, 1'b0);
      ticks(1); expect_cnt_flag("R1 R6 match", 32'd0, 1'b1);
      ticks(2); expect_cnt_flag("R10 sticky", 32'd2, 1'b1);
      wr(2'd3, 32'd1);
      rd(2'd3, v); chk("R10 write one keeps", v, 32'd1);
      wr(2'd3, 32'd0);
      rd(2'd3, v); chk("R10 clear", v, 32'd0);
   endtask

   task automatic t_gate;
      wr(2'd0, 32'd0);
      ticks(3); expect_cnt_flag("R11 run off", 32'd2, 1'b0);
      wr(2'd0, 32'd1);
      repeat (3) @(negedge clk);
      expect_cnt_flag("R11 no tick", 32'd2, 1'b0);
   endtask

   task automatic t_unbuffered;
      wr(2'd1, 32'd10);
      wr(2'd2, 32'd7);
      wr(2'd1, 32'd5);
      ticks(1); expect_cnt_flag("R3 passes new value", 32'd8, 1'b0);
      wr(2'd2, 32'hFFFF_FFFE);
      ticks(1); expect_cnt_flag("R2 full scale", 32'hFFFF_FFFF, 1'b0);
      ticks(1); expect_cnt_flag("R2 wrap silent", 32'd0, 1'b0);
      ticks(5); expect_cnt_flag("R3 reach", 32'd5, 1'b0);
      ticks(1); expect_cnt_flag("R3 match after wrap", 32'd0, 1'b1);
      wr(2'd3, 32'd0);
   endtask

   task automatic t_buffered;
      logic [31:0] v;
      wr(2'd0, 32'd9);
      wr(2'd1, 32'd2);
      rd(2'd1, v); chk("R4 readback", v, 32'd2);
      ticks(3); expect_cnt_flag("R4 old compare kept", 32'd3, 1'b0);
      ticks(2); expect_cnt_flag("R4 at old value", 32'd5, 1'b0);
      ticks(1); expect_cnt_flag("R5 update", 32'd0, 1'b1);
      wr(2'd3, 32'd0);
      ticks(2); expect_cnt_flag("R5 new period", 32'd2, 1'b0);
      ticks(1); expect_cnt_flag("R5 new match", 32'd0, 1'b1);
      wr(2'd3, 32'd0);
   endtask

   task automatic t_force;
      logic [31:0] v;
      wr(2'd1, 32'd7);
      ticks(1); expect_cnt_flag("R8 pre", 32'd1, 1'b0);
      wr(2'd0, 32'd25);
      expect_cnt_flag("R8 forced", 32'd0, 1'b1);
      rd(2'd0, v); chk("R8 self clear", v, 32'd9);
      wr(2'd3, 32'd0);
      ticks(7); expect_cnt_flag("R8 transferred", 32'd7, 1'b0);
      ticks(1); expect_cnt_flag("R8 match", 32'd0, 1'b1);
      wr(2'd3, 32'd0);
   endtask

   task automatic t_match_only;
      wr(2'd0, 32'd13);
      wr(2'd1, 32'd3);
      ticks(2);
      wr(2'd0, 32'd29);
      expect_cnt_flag("R9 forced no flag", 32'd0, 1'b0);
      ticks(3); expect_cnt_flag("R9 transfer", 32'd3, 1'b0);
      ticks(1); expect_cnt_flag("R9 match flags", 32'd0, 1'b1);
      wr(2'd3, 32'd0);
   endtask

   task automatic t_upd_off;
      wr(2'd0, 32'd11);
      wr(2'd1, 32'd6);
      ticks(3); expect_cnt_flag("R7 pre", 32'd3, 1'b0);
      ticks(1); expect_cnt_flag("R7 restart silent", 32'd0, 1'b0);
      ticks(3);
      ticks(1); expect_cnt_flag("R7 no transfer", 32'd0, 1'b0);
      wr(2'd0, 32'd9);
      ticks(4); expect_cnt_flag("R7 re-enabled", 32'd0, 1'b1);
      wr(2'd3, 32'd0);
      ticks(6); expect_cnt_flag("R5 late transfer", 32'd6, 1'b0);
      ticks(1); expect_cnt_flag("R5 late match", 32'd0, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_gate();
      t_unbuffered();
      t_buffered();
      t_force();
      t_match_only();
      t_upd_off();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule